// File: doc/BRIEF.md
# SPI status flag interrupt controller

This block keeps the four status flags and the enable bits of a double-buffered SPI peripheral, and turns them into two interrupt requests: one for the transmitter and one shared by the receiver and the error sources. The serial datapath reports its events as one-cycle strobes: a byte landed in the receive buffer, a byte left the transmit buffer for the shifter, an overrun was seen, or a mode fault was seen. The register file reports its bus accesses as one-cycle strobes: a status/control read, a receive data read, a transmit data write, and a control write with its data.

Flags that need software to acknowledge them (receive full, overrun, mode fault) are cleared by a two-step sequence. A status read that sees the flag set arms it, and the next bus access must then be the matching one: a data read for receive full and overrun, a control write for mode fault. The transmit empty flag is cleared by any transmit data write. A set event always wins over a clear in the same cycle and cancels a pending arm. Both requests are combinational from the registered flags and enables.

Every pin is a plain level or a one-cycle strobe. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure. At most one bus access strobe is high in any cycle.

Top module: `spi_flag_irq_ctrl`

## Requirements
- R1: A high `rx_load_stb` sets receive full (`status_q[0]`) at the next clock edge.
- R2: Receive full clears only when a status read sees it set and the next bus access is a data read (`data_rd`); idle cycles between them are allowed, and any other access in between cancels the sequence.
- R3: A high `tx_move_stb` sets transmit empty (`status_q[1]`) at the next clock edge.
- R4: A high `data_wr` clears transmit empty at the next edge, with no prior status read.
- R5: `tx_irq` is high exactly when transmit empty, transmit enable (`ctrl_q[1]`) and port enable (`ctrl_q[0]`) are all 1.
- R6: Receive full with receive enable (`ctrl_q[2]`) drives `rxerr_irq` high whatever the port enable.
- R7: With error enable (`ctrl_q[3]`) set, overrun (`status_q[2]`) or mode fault (`status_q[3]`) drives `rxerr_irq`; the request is the OR of the receive and error terms.
- R8: While mode fault enable (`ctrl_q[4]`) is 0, `mfault_stb` never sets mode fault.
- R9: Synchronous active-high `rst` gives `status_q` = 4'b0010, `ctrl_q` = 0 and both requests low.
- R10: A set event in the same cycle as a clear keeps the flag set and cancels any pending arm of that flag.
- R11: Overrun clears by a status read seeing it set then a data read as the next access; mode fault clears by a status read seeing it set then a control write as the next access.
- R12: A request falls in the same cycle its flag is seen cleared, i.e. one edge after the clearing access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_load_stb | input | 1 | Byte moved from shifter into receive buffer |
| tx_move_stb | input | 1 | Byte moved from transmit buffer into shifter |
| ovr_stb | input | 1 | Overrun detected |
| mfault_stb | input | 1 | Mode fault detected |
| stat_rd | input | 1 | Status/control register read |
| data_rd | input | 1 | Receive data register read |
| data_wr | input | 1 | Transmit data register write |
| ctrl_wr | input | 1 | Control register write |
| ctrl_wdata | input | CTRL_W | Control write data |
| status_q | output | 4 | Flags: bit3 mode fault, bit2 overrun, bit1 transmit empty, bit0 receive full |
| ctrl_q | output | CTRL_W | Enables: bit4 mode fault enable, bit3 error, bit2 receive, bit1 transmit, bit0 port enable |
| tx_irq | output | 1 | Transmitter interrupt request |
| rxerr_irq | output | 1 | Receiver/error interrupt request |

## Verification
The hardest situation to reach is a clearing access that arrives while a flag is armed and a new set event for the same flag lands in the same cycle, or a stray access slips between the status read and the data read. Directed sequences build each of these orders deliberately, with idle gaps, interposed writes and coincident strobes, and a long random phase with sparse bus accesses and frequent datapath strobes lands many more arm, cancel and re-arm orders while a behavioural model in the bench is compared every cycle.

// File: rtl/spi_fic_pkg.sv
package spi_fic_pkg;

  // Status flag positions
  localparam int FLG_RX  = 0;
  localparam int FLG_TX  = 1;
  localparam int FLG_OVR = 2;
  localparam int FLG_MF  = 3;
  localparam int NUM_FLAGS = 4;

  // Control bit positions
  localparam int CB_PORT_EN = 0;
  localparam int CB_TX_IE   = 1;
  localparam int CB_RX_IE   = 2;
  localparam int CB_ERR_IE  = 3;
  localparam int CB_MF_EN   = 4;
  localparam int CTRL_USED  = 5;

  // Flags cleared by the two-step acknowledge sequence
  localparam int NUM_ARMED = 3;

  typedef enum logic [1:0] {
    ACK_DATA_RD = 2'd0,
    ACK_CTRL_WR = 2'd1
  } ack_kind_e;

  typedef struct packed {
    logic mf_en;
    logic err_ie;
    logic rx_ie;
    logic tx_ie;
    logic port_en;
  } ctrl_t;

  typedef struct packed {
    logic stat_rd;
    logic data_rd;
    logic data_wr;
    logic ctrl_wr;
  } bus_acc_t;

endpackage

// File: rtl/spi_fic_armed_flag.sv
module spi_fic_armed_flag
  import spi_fic_pkg::*;
#(
  parameter ack_kind_e ACK_KIND = ACK_DATA_RD
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     set_evt,
  input  bus_acc_t acc,
  output logic     flag_q
);

  logic armed_q;
  logic ack_hit;
  logic any_acc;
  logic see_set;

  always_comb begin
    if (ACK_KIND == ACK_CTRL_WR) ack_hit = acc.ctrl_wr;
    else                         ack_hit = acc.data_rd;
  end

  assign any_acc = acc.stat_rd | acc.data_rd | acc.data_wr | acc.ctrl_wr;
  assign see_set = acc.stat_rd & flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      // set event dominates any clear in the same cycle
      if (set_evt)                 flag_q <= 1'b1;
      else if (armed_q && ack_hit) flag_q <= 1'b0;

      if (set_evt)      armed_q <= 1'b0;
      else if (see_set) armed_q <= 1'b1;
      else if (any_acc) armed_q <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_fic_ctrl_reg.sv
module spi_fic_ctrl_reg
  import spi_fic_pkg::*;
#(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output ctrl_t             ctrl,
  output logic [CTRL_W-1:0] ctrl_word
);

  localparam int PAD_W = CTRL_W - CTRL_USED;

  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst)     ctrl_q <= '0;
    else if (wr) ctrl_q <= ctrl_t'(wdata[CTRL_USED-1:0]);
  end

  assign ctrl = ctrl_q;

  generate
    if (PAD_W > 0) begin : g_pad
      assign ctrl_word = {{PAD_W{1'b0}}, ctrl_q};
    end else begin : g_nopad
      assign ctrl_word = ctrl_q;
    end
  endgenerate

endmodule

// File: rtl/spi_fic_irq_combine.sv
module spi_fic_irq_combine
  import spi_fic_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] flags,
  input  ctrl_t                ctrl,
  output logic                 tx_irq,
  output logic                 rxerr_irq
);

  logic rx_term;
  logic err_term;

  assign tx_irq   = flags[FLG_TX] & ctrl.tx_ie & ctrl.port_en;
  assign rx_term  = flags[FLG_RX] & ctrl.rx_ie;
  assign err_term = ctrl.err_ie & (flags[FLG_OVR] | flags[FLG_MF]);
  assign rxerr_irq = rx_term | err_term;

endmodule

// File: rtl/spi_flag_irq_ctrl.sv
module spi_flag_irq_ctrl
  import spi_fic_pkg::*;
#(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_load_stb,
  input  logic              tx_move_stb,
  input  logic              ovr_stb,
  input  logic              mfault_stb,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [3:0]        status_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              tx_irq,
  output logic              rxerr_irq
);

  bus_acc_t acc;
  ctrl_t    ctrl;
  logic     tx_empty_q;
  logic [NUM_ARMED-1:0] armed_set;
  logic [NUM_ARMED-1:0] armed_flag;

  // flag index served by each armed cell
  localparam int ARMED_IDX [NUM_ARMED] = '{FLG_RX, FLG_OVR, FLG_MF};

  assign acc.stat_rd = stat_rd;
  assign acc.data_rd = data_rd;
  assign acc.data_wr = data_wr;
  assign acc.ctrl_wr = ctrl_wr;

  spi_fic_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr       (ctrl_wr),
    .wdata    (ctrl_wdata),
    .ctrl     (ctrl),
    .ctrl_word(ctrl_q)
  );

  assign armed_set[0] = rx_load_stb;
  assign armed_set[1] = ovr_stb;
  assign armed_set[2] = mfault_stb & ctrl.mf_en;

  generate
    for (genvar i = 0; i < NUM_ARMED; i++) begin : g_armed
      if (ARMED_IDX[i] == FLG_MF) begin : g_ctrl_ack
        spi_fic_armed_flag #(.ACK_KIND(ACK_CTRL_WR)) u_flag (
          .clk    (clk),
          .rst    (rst),
          .set_evt(armed_set[i]),
          .acc    (acc),
          .flag_q (armed_flag[i])
        );
      end else begin : g_data_ack
        spi_fic_armed_flag #(.ACK_KIND(ACK_DATA_RD)) u_flag (
          .clk    (clk),
          .rst    (rst),
          .set_evt(armed_set[i]),
          .acc    (acc),
          .flag_q (armed_flag[i])
        );
      end
    end
  endgenerate

  // transmit empty: set by buffer move, cleared by a data write
  always_ff @(posedge clk) begin
    if (rst)              tx_empty_q <= 1'b1;
    else if (tx_move_stb) tx_empty_q <= 1'b1;
    else if (data_wr)     tx_empty_q <= 1'b0;
  end

  always_comb begin
    status_q = '0;
    status_q[FLG_TX] = tx_empty_q;
    for (int i = 0; i < NUM_ARMED; i++) status_q[ARMED_IDX[i]] = armed_flag[i];
  end

  spi_fic_irq_combine u_irq (
    .flags    (status_q),
    .ctrl     (ctrl),
    .tx_irq   (tx_irq),
    .rxerr_irq(rxerr_irq)
  );

endmodule

// File: rtl/spi_flag_irq_ctrl_chk.sv
module spi_flag_irq_ctrl_chk #(
  parameter int CTRL_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_load_stb,
  input logic              tx_move_stb,
  input logic              ovr_stb,
  input logic              mfault_stb,
  input logic              stat_rd,
  input logic              data_rd,
  input logic              data_wr,
  input logic              ctrl_wr,
  input logic [CTRL_W-1:0] ctrl_wdata,
  input logic [3:0]        status_q,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              tx_irq,
  input logic              rxerr_irq
);

  assert_rx_set_R1: assert property (@(posedge clk) disable iff (rst)
    rx_load_stb |=> status_q[0]);

  assert_rx_clear_by_read_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(status_q[0]) |-> $past(data_rd));

  assert_tx_set_R3: assert property (@(posedge clk) disable iff (rst)
    tx_move_stb |=> status_q[1]);

  assert_tx_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !tx_move_stb) |=> !status_q[1]);

  assert_tx_irq_gated_R5: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[0] |-> !tx_irq);

  assert_rx_irq_R6: assert property (@(posedge clk) disable iff (rst)
    (status_q[0] && ctrl_q[2]) |-> rxerr_irq);

  assert_err_irq_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[3] && (status_q[2] || status_q[3])) |-> rxerr_irq);

  assert_mf_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[3]) |-> $past(ctrl_q[4] && mfault_stb));

  assert_ovr_clear_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(status_q[2]) |-> $past(data_rd));

  assert_mf_clear_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(status_q[3]) |-> $past(ctrl_wr));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    ovr_stb |=> status_q[2]);

endmodule

bind spi_flag_irq_ctrl spi_flag_irq_ctrl_chk #(.CTRL_W(CTRL_W)) u_chk (.*);

// File: tb/spi_flag_irq_ctrl_bench.sv
`timescale 1ns/1ps
module spi_flag_irq_ctrl_bench;

  localparam int CTRL_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_load_stb = 0, tx_move_stb = 0, ovr_stb = 0, mfault_stb = 0;
  logic stat_rd = 0, data_rd = 0, data_wr = 0, ctrl_wr = 0;
  logic [CTRL_W-1:0] ctrl_wdata = '0;
  logic [3:0]        status_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              tx_irq, rxerr_irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R9";
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_flag_irq_ctrl #(.CTRL_W(CTRL_W)) u_spi_flag_irq_ctrl (.*);

  // behavioural reference: flags, enables, pending acknowledges
  bit m_rx, m_tx, m_ov, m_mf;
  bit [4:0] m_en;
  bit p_rx, p_ov, p_mf;

  always @(posedge clk) begin
    bit any, n_rx, n_ov, n_mf, n_tx;
    if (rst) begin
      m_rx = 0; m_tx = 1; m_ov = 0; m_mf = 0; m_en = '0;
      p_rx = 0; p_ov = 0; p_mf = 0;
    end else begin
      any  = stat_rd || data_rd || data_wr || ctrl_wr;
      n_rx = rx_load_stb ? 1'b1 : ((p_rx && data_rd) ? 1'b0 : m_rx);
      n_ov = ovr_stb ? 1'b1 : ((p_ov && data_rd) ? 1'b0 : m_ov);
      n_mf = (mfault_stb && m_en[4]) ? 1'b1 : ((p_mf && ctrl_wr) ? 1'b0 : m_mf);
      n_tx = tx_move_stb ? 1'b1 : (data_wr ? 1'b0 : m_tx);
      p_rx = rx_load_stb ? 1'b0 : (stat_rd && m_rx) ? 1'b1 : any ? 1'b0 : p_rx;
      p_ov = ovr_stb ? 1'b0 : (stat_rd && m_ov) ? 1'b1 : any ? 1'b0 : p_ov;
      p_mf = (mfault_stb && m_en[4]) ? 1'b0 : (stat_rd && m_mf) ? 1'b1 : any ? 1'b0 : p_mf;
      if (ctrl_wr) m_en = ctrl_wdata[4:0];
      m_rx = n_rx; m_ov = n_ov; m_mf = n_mf; m_tx = n_tx;
    end
  end

  function automatic bit [3:0] exp_status();
    return {m_mf, m_ov, m_tx, m_rx};
  endfunction

  function automatic bit exp_tx_irq();
    return m_tx && m_en[1] && m_en[0];
  endfunction

  function automatic bit exp_rx_irq();
    return (m_rx && m_en[2]) || (m_en[3] && (m_ov || m_mf));
  endfunction

  // every-cycle comparison (R12 covers request timing)
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (status_q !== exp_status() || ctrl_q !== {3'b000, m_en} ||
          tx_irq !== exp_tx_irq() || rxerr_irq !== exp_rx_irq()) begin
        errors++;
        $display("FAIL %s/R12 cycle compare: status=%b ctrl=%h tx=%b rx=%b expected status=%b ctrl=%h tx=%b rx=%b",
                 cur_req, status_q, ctrl_q, tx_irq, rxerr_irq, exp_status(),
                 {3'b000, m_en}, exp_tx_irq(), exp_rx_irq());
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic strobe(input bit rl, input bit tm, input bit ov, input bit mf,
                        input bit sr, input bit dr, input bit dw, input bit cw,
                        input logic [7:0] wd);
    rx_load_stb = rl; tx_move_stb = tm; ovr_stb = ov; mfault_stb = mf;
    stat_rd = sr; data_rd = dr; data_wr = dw; ctrl_wr = cw; ctrl_wdata = wd;
    @(posedge clk); #1;
    rx_load_stb = 0; tx_move_stb = 0; ovr_stb = 0; mfault_stb = 0;
    stat_rd = 0; data_rd = 0; data_wr = 0; ctrl_wr = 0;
  endtask

  task automatic report();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    idle(3);
    rst = 0;
    idle(1);
    cur_req = "R9";
    chk("R9 status reset", {4'h0, status_q}, 8'h02);
    chk("R9 ctrl reset", ctrl_q, 8'h00);
    chk("R9 irqs reset", {6'd0, tx_irq, rxerr_irq}, 8'h00);

    cur_req = "R1";
    strobe(1,0,0,0, 0,0,0,0, 8'h00);
    chk("R1 rx full set", {7'd0, status_q[0]}, 8'h01);

    cur_req = "R2";
    strobe(0,0,0,0, 0,1,0,0, 8'h00);
    chk("R2 data read alone keeps flag", {7'd0, status_q[0]}, 8'h01);
    strobe(0,0,0,0, 1,0,0,0, 8'h00);
    strobe(0,0,0,0, 0,0,1,0, 8'h00);
    strobe(0,0,0,0, 0,1,0,0, 8'h00);
    chk("R2 interposed write cancels", {7'd0, status_q[0]}, 8'h01);
    strobe(0,0,0,0, 1,0,0,0, 8'h00);
    idle(3);
    strobe(0,0,0,0, 0,1,0,0, 8'h00);
    chk("R2 status then data read clears", {7'd0, status_q[0]}, 8'h00);

    cur_req = "R10";
    strobe(1,0,0,0, 0,0,0,0, 8'h00);
    strobe(0,0,0,0, 1,0,0,0, 8'h00);
    strobe(1,0,0,0, 0,0,0,0, 8'h00);
    strobe(0,0,0,0, 0,1,0,0, 8'h00);
    chk("R10 set event disarms", {7'd0, status_q[0]}, 8'h01);
    strobe(0,0,0,0, 1,0,0,0, 8'h00);
    strobe(1,0,0,0, 0,1,0,0, 8'h00);
    chk("R10 set wins over clear", {7'd0, status_q[0]}, 8'h01);

    cur_req = "R4";
    strobe(0,0,0,0, 0,0,1,0, 8'h00);
    chk("R4 write clears tx empty", {7'd0, status_q[1]}, 8'h00);
    cur_req = "R3";
    strobe(0,1,0,0, 0,0,0,0, 8'h00);
    chk("R3 move sets tx empty", {7'd0, status_q[1]}, 8'h01);
    strobe(0,1,0,0, 0,0,1,0, 8'h00);
    chk("R3 move wins over write", {7'd0, status_q[1]}, 8'h01);

    cur_req = "R5";
    strobe(0,0,0,0, 0,0,0,1, 8'h02);
    chk("R5 no request with port disabled", {7'd0, tx_irq}, 8'h00);
    strobe(0,0,0,0, 0,0,0,1, 8'h03);
    chk("R5 request with port enabled", {7'd0, tx_irq}, 8'h01);
    cur_req = "R12";
    strobe(0,0,0,0, 0,0,1,0, 8'h00);
    chk("R12 tx request falls with flag", {7'd0, tx_irq}, 8'h00);

    cur_req = "R6";
    strobe(0,0,0,0, 0,0,0,1, 8'h04);
    chk("R6 rx request without port enable", {7'd0, rxerr_irq}, 8'h01);
    strobe(0,0,0,0, 1,0,0,0, 8'h00);
    strobe(0,0,0,0, 0,1,0,0, 8'h00);
    chk("R12 rx request falls with flag", {7'd0, rxerr_irq}, 8'h00);

    cur_req = "R7";
    strobe(0,0,0,0, 0,0,0,1, 8'h08);
    strobe(0,0,1,0, 0,0,0,0, 8'h00);
    chk("R7 overrun request", {7'd0, rxerr_irq}, 8'h01);
    cur_req = "R11";
    strobe(0,0,0,0, 1,0,0,0, 8'h00);
    strobe(0,0,0,0, 0,1,0,0, 8'h00);
    chk("R11 overrun cleared", {7'd0, status_q[2]}, 8'h00);

    cur_req = "R8";
    strobe(0,0,0,1, 0,0,0,0, 8'h00);
    chk("R8 mode fault blocked", {7'd0, status_q[3]}, 8'h00);
    strobe(0,0,0,0, 0,0,0,1, 8'h18);
    strobe(0,0,0,1, 0,0,0,0, 8'h00);
    chk("R8 mode fault set when enabled", {7'd0, status_q[3]}, 8'h01);
    chk("R7 mode fault request", {7'd0, rxerr_irq}, 8'h01);
    cur_req = "R11";
    strobe(0,0,0,0, 1,0,0,0, 8'h00);
    strobe(0,0,0,0, 0,1,0,0, 8'h00);
    chk("R11 data read does not clear mode fault", {7'd0, status_q[3]}, 8'h01);
    strobe(0,0,0,0, 1,0,0,0, 8'h00);
    strobe(0,0,0,0, 0,0,0,1, 8'h18);
    chk("R11 control write clears mode fault", {7'd0, status_q[3]}, 8'h00);

    cur_req = "R2/R10/R11 random";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 10;
      strobe(($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 8) == 0,
             ($urandom % 8) == 0, r == 0 || r == 5, r == 1 || r == 6, r == 2,
             r == 3, 8'($urandom));
    end
    idle(2);
    report();
  end

endmodule